// File: doc/BRIEF.md
# Operand-Caching Wide Multiplier

This block multiplies two unsigned operands of sixteen 16-bit words each and produces the full 32-word product, with no modular reduction. It uses a single 16x16 multiply-accumulate datapath. Each operand word i carries weight 2^(16i), and word 0 is the least significant. The block reads both operands word by word from an external word-addressed memory and writes the product words to an external output memory.

The work is split into row passes. Each pass caches four words of the second operand, y, in local registers. Within a pass, the columns of the product are formed one after another. For each product term the streamed word of x is loaded into the multiplier's second input register, and that load starts the multiply. The first input register holds a cached y word. It keeps its value until a term needs a different cached word. The terms of a column are visited in an order that alternates with the column's parity. As a result, a column usually begins with the same cached word that ended the column before it, and that word is not reloaded.

A 40-bit accumulator adds a column's terms to the running partial word held from earlier passes. The low 16 bits are stored, and the carry is shifted explicitly into the next column. A column is written out only once no later pass can change it. The block counts every load into either multiplier input register, so the saving over a plain schoolbook order can be observed.

Top module: `opmul_core`

## Requirements
- R1: After reset, busy, done and wr_en are 0 and load_count is 0.
- R2: For any operands, the 2N words written are x*y, with word k of the product written at wr_addr k. x is read from addresses 0..N-1 and y from addresses N..2N-1, both little-endian.
- R3: Each operation writes exactly 2N words, at addresses 0, 1, ..., 2N-1 in ascending order. wr_en is asserted only while busy is 1.
- R4: Each word of y, at addresses N..2N-1, is read exactly once per operation, into the row cache.
- R5: Every product term loads the second multiplier input once. The first input is loaded only when the cached word it needs differs from the one it already holds, or at the first term of a row pass. Columns of even index within a pass visit cached words from highest to lowest, and odd columns from lowest to highest. load_count counts the loads into both inputs, and for N=16 with rows of 4 it totals 448, below the 512 loads of a schoolbook order.
- R6: A start pulse while busy is 1 is ignored. The running operation's product, load count and latency are unchanged.
- R7: done is high for exactly one cycle, in the cycle after the write to address 2N-1. busy is 0 in that cycle.
- R8: load_count clears to 0 on the cycle after a start is accepted. It holds its value while the block is idle.
- R9: The number of cycles from start to done does not depend on the operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when idle |
| rd_addr | output | AW (5) | Operand memory word address |
| rd_data | input | W (16) | Operand memory word, combinational read |
| wr_en | output | 1 | Product word write strobe |
| wr_addr | output | AW (5) | Product word index |
| wr_data | output | W (16) | Product word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| load_count | output | CW (10) | Multiplier input loads in the current or last operation |

## Verification
On every cycle, the checker enforces the ascending write order and confines writes to the busy window. It also checks that the load counter grows by at most two per cycle, clears on an accepted start and stays still while idle, and that done is a single pulse following the final write. Only the bench scenarios can show the arithmetic: full products across sweeps of placed word patterns, all-ones carry chains and pseudo-random operands. The bench also confirms the exact load total implied by the alternating column order, the single read of each y word, the fixed latency, and that a start during an operation has no effect.

// File: rtl/opmul_pkg.sv
package opmul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_OPEN,
        ST_MAC,
        ST_DRAIN,
        ST_CLOSE
    } seq_state_e;

    typedef struct packed {
        logic clear;     // zero the accumulator
        logic add_part;  // add stored partial word of the column
        logic shift;     // drop low word, keep carry for next column
        logic load_a;    // load cached word into first input
        logic load_b;    // load streamed word into second input, fires product
    } mac_ctrl_t;

    // lowest cached offset that has a term in pass column t
    function automatic int col_lo(input int t, input int n);
        return (t > n - 1) ? t - (n - 1) : 0;
    endfunction

    // highest cached offset that has a term in pass column t
    function automatic int col_hi(input int t, input int row);
        return (t < row - 1) ? t : row - 1;
    endfunction

endpackage

// File: rtl/opmul_mac.sv
module opmul_mac
    import opmul_pkg::*;
#(
    parameter int W     = 16,
    parameter int ACC_W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  mac_ctrl_t    ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] part_in,
    output logic [W-1:0] acc_low
);
    logic [W-1:0]     op_a_q;
    logic [W-1:0]     op_b_q;
    logic             fire_q;
    logic [ACC_W-1:0] acc_q;
    logic [2*W-1:0]   prod;
    logic [ACC_W-1:0] base;

    assign prod = op_a_q * op_b_q;

    always_comb begin
        if (ctrl.clear)
            base = '0;
        else if (ctrl.shift)
            base = acc_q >> W;
        else if (ctrl.add_part)
            base = acc_q + ACC_W'(part_in);
        else
            base = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a_q <= '0;
            op_b_q <= '0;
            fire_q <= 1'b0;
            acc_q  <= '0;
        end else begin
            if (ctrl.load_a) op_a_q <= a_in;
            if (ctrl.load_b) op_b_q <= b_in;
            fire_q <= ctrl.load_b;
            acc_q  <= base + (fire_q ? ACC_W'(prod) : '0);
        end
    end

    assign acc_low = acc_q[W-1:0];
endmodule

// File: rtl/opmul_part_buf.sv
module opmul_part_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_all,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/opmul_seq.sv
module opmul_seq
    import opmul_pkg::*;
#(
    parameter int N   = 16,
    parameter int ROW = 4,
    parameter int W   = 16,
    parameter int AW  = 5,
    parameter int CW  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  rd_data,
    output logic [AW-1:0] rd_addr,
    output mac_ctrl_t     ctrl,
    output logic [W-1:0]  a_word,
    output logic          buf_clear,
    output logic          buf_we,
    output logic [AW-1:0] buf_addr,
    output logic          wr_en,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] load_count
);
    localparam int ROWS   = N / ROW;
    localparam int LAST_T = N + ROW - 1;
    localparam int TW     = $clog2(N + ROW);
    localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int KW     = (ROW > 1) ? $clog2(ROW) : 1;

    seq_state_e    state_q;
    logic [RW-1:0] row_q;
    logic [TW-1:0] t_q;
    logic [KW-1:0] k_q;
    logic [KW-1:0] fill_q;
    logic [KW-1:0] held_q;
    logic          held_v_q;
    logic          desc_q;
    logic          done_q;
    logic [CW-1:0] count_q;
    logic [W-1:0]  cache_q [ROW];

    int   col_base;
    int   lo_i;
    int   hi_i;
    logic need_a;
    logic last_row;

    assign col_base = int'(row_q) * ROW;
    assign lo_i     = col_lo(int'(t_q), N);
    assign hi_i     = col_hi(int'(t_q), ROW);
    assign need_a   = !held_v_q || (held_q != k_q);
    assign last_row = (row_q == RW'(ROWS - 1));

    always_comb begin
        rd_addr   = '0;
        ctrl      = '0;
        buf_clear = 1'b0;
        buf_we    = 1'b0;
        buf_addr  = '0;
        wr_en     = 1'b0;
        case (state_q)
            ST_IDLE:  buf_clear = start;
            ST_FILL: begin
                rd_addr    = AW'(N + col_base + int'(fill_q));
                ctrl.clear = 1'b1;
            end
            ST_OPEN: begin
                buf_addr      = AW'(col_base + int'(t_q));
                ctrl.add_part = 1'b1;
            end
            ST_MAC: begin
                rd_addr     = AW'(int'(t_q) - int'(k_q));
                ctrl.load_b = 1'b1;
                ctrl.load_a = need_a;
            end
            ST_CLOSE: begin
                buf_addr   = AW'(col_base + int'(t_q));
                buf_we     = 1'b1;
                ctrl.shift = 1'b1;
                wr_en      = (int'(t_q) < ROW) || last_row;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            row_q    <= '0;
            t_q      <= '0;
            k_q      <= '0;
            fill_q   <= '0;
            held_q   <= '0;
            held_v_q <= 1'b0;
            desc_q   <= 1'b0;
            done_q   <= 1'b0;
            count_q  <= '0;
            for (int i = 0; i < ROW; i++) cache_q[i] <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_FILL;
                        row_q   <= '0;
                        fill_q  <= '0;
                        count_q <= '0;
                    end
                end
                ST_FILL: begin
                    cache_q[fill_q] <= rd_data;
                    held_v_q        <= 1'b0;
                    if (fill_q == KW'(ROW - 1)) begin
                        state_q <= ST_OPEN;
                        t_q     <= '0;
                    end else begin
                        fill_q <= fill_q + 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (lo_i > hi_i) begin
                        state_q <= ST_DRAIN;
                    end else begin
                        desc_q  <= ~t_q[0];
                        k_q     <= t_q[0] ? KW'(lo_i) : KW'(hi_i);
                        state_q <= ST_MAC;
                    end
                end
                ST_MAC: begin
                    held_q   <= k_q;
                    held_v_q <= 1'b1;
                    count_q  <= count_q + (need_a ? CW'(2) : CW'(1));
                    if (desc_q) begin
                        if (int'(k_q) == lo_i) state_q <= ST_DRAIN;
                        else                   k_q     <= k_q - 1'b1;
                    end else begin
                        if (int'(k_q) == hi_i) state_q <= ST_DRAIN;
                        else                   k_q     <= k_q + 1'b1;
                    end
                end
                ST_DRAIN: state_q <= ST_CLOSE;
                ST_CLOSE: begin
                    if (int'(t_q) == LAST_T) begin
                        if (last_row) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            row_q   <= row_q + 1'b1;
                            fill_q  <= '0;
                            state_q <= ST_FILL;
                        end
                    end else begin
                        t_q     <= t_q + 1'b1;
                        state_q <= ST_OPEN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign a_word     = cache_q[k_q];
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign load_count = count_q;
endmodule

// File: rtl/opmul_core.sv
module opmul_core
    import opmul_pkg::*;
#(
    parameter int N     = 16,
    parameter int W     = 16,
    parameter int ROW   = 4,
    parameter int ACC_W = 40,
    localparam int AW   = $clog2(2 * N),
    localparam int CW   = $clog2(2 * N * N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [AW-1:0] rd_addr,
    input  logic [W-1:0]  rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] load_count
);
    mac_ctrl_t     ctrl;
    logic [W-1:0]  a_word;
    logic [W-1:0]  acc_low;
    logic [W-1:0]  part_word;
    logic          buf_clear;
    logic          buf_we;
    logic [AW-1:0] buf_addr;

    opmul_seq #(.N(N), .ROW(ROW), .W(W), .AW(AW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .ctrl       (ctrl),
        .a_word     (a_word),
        .buf_clear  (buf_clear),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .wr_en      (wr_en),
        .busy       (busy),
        .done       (done),
        .load_count (load_count)
    );

    opmul_mac #(.W(W), .ACC_W(ACC_W)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .a_in    (a_word),
        .b_in    (rd_data),
        .part_in (part_word),
        .acc_low (acc_low)
    );

    opmul_part_buf #(.W(W), .DEPTH(2 * N), .AW(AW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear_all (buf_clear),
        .we        (buf_we),
        .addr      (buf_addr),
        .wdata     (acc_low),
        .rdata     (part_word)
    );

    assign wr_addr = buf_addr;
    assign wr_data = acc_low;
endmodule

// File: rtl/opmul_check.sv
module opmul_check #(
    parameter int N  = 16,
    parameter int AW = 5,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [CW-1:0] load_count
);
    logic [AW-1:0] exp_addr_q;

    always_ff @(posedge clk) begin
        if (rst)                 exp_addr_q <= '0;
        else if (start && !busy) exp_addr_q <= '0;
        else if (wr_en)          exp_addr_q <= exp_addr_q + 1'b1;
    end

    a_r3_write_order: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_addr == exp_addr_q);

    a_r3_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        busy |=> (load_count == $past(load_count))
              || (load_count == $past(load_count) + CW'(1))
              || (load_count == $past(load_count) + CW'(2)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(wr_en) && ($past(wr_addr) == AW'(2 * N - 1)));

    a_r8_count_clear: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> load_count == '0);

    a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(load_count));
endmodule

bind opmul_core opmul_check #(.N(N), .AW(AW), .CW(CW)) u_check (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .load_count (load_count)
);

// File: tb/opmul_core_test.sv
module opmul_core_test;
    localparam int N     = 16;
    localparam int W     = 16;
    localparam int ROW   = 4;
    localparam int AW    = $clog2(2 * N);
    localparam int CW    = $clog2(2 * N * N + 1);
    localparam int XW    = N * W;
    localparam int PW    = 2 * XW;
    localparam int LIMIT = 5000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [W-1:0]  rd_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  wr_data;
    logic          busy;
    logic          done;
    logic [CW-1:0] load_count;

    logic [W-1:0] in_mem  [2 * N];
    logic [W-1:0] out_mem [2 * N];
    int  wr_cnt;
    int  done_seen;
    int  yreads;
    int  checks = 0;
    int  fails  = 0;
    int  ref_lat = -1;
    bit  finished = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    assign rd_data = in_mem[rd_addr];

    opmul_core uut (
        .clk(clk), .rst(rst), .start(start),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .load_count(load_count)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            out_mem[wr_addr] <= wr_data;
            wr_cnt = wr_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (done) done_seen = done_seen + 1;
        if (busy && int'(rd_addr) >= N) yreads = yreads + 1;
    end

    task automatic check(input bit ok, input string req,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // load total from the ordering rule stated in R5
    function automatic int expected_loads();
        int tot = 0;
        for (int r = 0; r < N / ROW; r++) begin
            int held = -1;
            for (int t = 0; t < N + ROW; t++) begin
                int lo = (t > N - 1) ? t - (N - 1) : 0;
                int hi = (t < ROW - 1) ? t : ROW - 1;
                if (lo <= hi) begin
                    for (int s = 0; s <= hi - lo; s++) begin
                        int k = (t % 2 == 0) ? hi - s : lo + s;
                        tot += 1;
                        if (k != held) tot += 1;
                        held = k;
                    end
                end
            end
        end
        return tot;
    endfunction

    function automatic logic [W-1:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[W-1:0];
    endfunction

    task automatic do_op(input logic [XW-1:0] x, input logic [XW-1:0] y,
                         input bit mid_start);
        logic [PW-1:0] expv;
        logic [PW-1:0] got;
        int cycles;
        for (int i = 0; i < N; i++) begin
            in_mem[i]     = x[i*W +: W];
            in_mem[N + i] = y[i*W +: W];
        end
        for (int i = 0; i < 2 * N; i++) out_mem[i] = '0;
        wr_cnt = 0; done_seen = 0; yreads = 0;
        expv = {{XW{1'b0}}, x} * {{XW{1'b0}}, y};
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cycles = 1;
        // R8: counter cleared on the cycle after accepted start
        check(load_count == '0, "R8 count clear", PW'(load_count), '0);
        while (!done && cycles < LIMIT) begin
            start = (mid_start && (cycles == 100 || cycles == 300));
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        check(cycles < LIMIT, "R9 watchdog", PW'(cycles), PW'(LIMIT));
        // R7: busy low while done high, then done drops
        check(!busy, "R7 busy at done", PW'(busy), '0);
        @(negedge clk);
        check(!done, "R7 done one cycle", PW'(done), '0);
        check(done_seen == 1, "R7 done count", PW'(done_seen), PW'(1));
        for (int i = 0; i < 2 * N; i++) got[i*W +: W] = out_mem[i];
        check(got == expv, "R2 product", got, expv);
        check(wr_cnt == 2 * N, "R3 write count", PW'(wr_cnt), PW'(2 * N));
        check(yreads == N, "R4 y reads", PW'(yreads), PW'(N));
        check(int'(load_count) == expected_loads(), "R5 load count",
              PW'(load_count), PW'(expected_loads()));
        check(int'(load_count) < 2 * N * N, "R5 below schoolbook",
              PW'(load_count), PW'(2 * N * N));
        if (ref_lat < 0) ref_lat = cycles;
        check(cycles == ref_lat, "R9 fixed latency", PW'(cycles), PW'(ref_lat));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [XW-1:0] x;
        logic [XW-1:0] y;
        logic [CW-1:0] held_cnt;
        for (int i = 0; i < 2 * N; i++) in_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !wr_en, "R1 reset outputs",
              PW'({busy, done, wr_en}), '0);
        check(load_count == '0, "R1 reset count", PW'(load_count), '0);

        do_op('0, '0, 0);
        do_op({XW{1'b1}}, {XW{1'b1}}, 0);            // longest carry chains
        do_op(XW'(1), {XW{1'b1}}, 0);
        do_op({(XW/4){4'hA}}, {(XW/4){4'h5}}, 0);

        // placed single words, sweep over positions
        for (int i = 0; i < N; i += 3) begin
            for (int j = 0; j < N; j += 3) begin
                x = XW'(16'hFFFF) << (i * W);
                y = XW'(16'hFFFF) << (j * W);
                do_op(x, y, 0);
            end
        end

        // pseudo-random operands
        for (int n = 0; n < 8; n++) begin
            for (int i = 0; i < N; i++) begin
                x[i*W +: W] = next_rand();
                y[i*W +: W] = next_rand();
            end
            do_op(x, y, 0);
        end

        // R6: start pulses during an operation are ignored
        do_op(x, {XW{1'b1}}, 1);

        // R8: count holds while idle
        held_cnt = load_count;
        repeat (10) @(negedge clk);
        check(load_count == held_cnt, "R8 hold idle", PW'(load_count), PW'(held_cnt));
        check(!busy, "R6 idle after run", PW'(busy), '0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule